// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache Controller

This block is a data cache that sits between a processor load/store port and a slower memory port that moves whole blocks. The cache is organised as a number of sets, each holding several ways; every line carries a valid flag, a dirty flag, a stored tag and one block of data. A 32-bit processor address is split into a byte offset inside the block, a set index and a tag. Loads and stores that find their line complete in the same cycle they are presented. Loads and stores that do not find it hold the processor in a stall while the controller frees a line, fetches the block and then completes the access.

Stores are write-back: a store that finds its line changes only the cached copy and marks it dirty. A dirty line is written to memory only when it is chosen for replacement. A store that misses first brings the block into the cache and then merges its enabled bytes into it. The line to replace in a set is the lowest-numbered empty way if one exists, or else the way used longest ago, as kept by a per-set age tracker.

The processor holds its request and all its request fields steady while the stall output is high. The memory side answers each request with a one-cycle acknowledge after any number of cycles.

Top module: `cache_wb_ctrl`

## Requirements
- R1: The address splits into a byte offset of log2(BLOCK_BYTES) bits, a set index of log2(SETS) bits above it, and a tag of the remaining upper bits; a word inside the block is picked by address bits [OFF_W-1:2]. With the defaults (4 sets, 2 ways, 16-byte blocks) the set index is address bits [5:4], so lines with different index bits never displace each other.
- R2: A synchronous active-low reset clears every valid flag and returns the controller to its lookup state, with cpu_stall and mem_req low; the first access to any address after reset misses.
- R3: A hit needs a way in the indexed set that is valid and whose stored tag equals the address tag; a hit keeps cpu_stall low, drives the addressed word on cpu_rdata in the same cycle, and causes no memory traffic.
- R4: A miss raises cpu_stall in the cycle it is presented; cpu_stall stays high until the cycle after the refill acknowledge, in which it falls and the access completes. The refill is a read request (mem_we low) whose address is the block-aligned request address.
- R5: When the indexed set has one or more invalid ways, a miss fills the lowest-numbered invalid way and evicts nothing.
- R6: When every way of the set is valid, a miss replaces the way least recently hit or filled.
- R7: A store hit updates only the cached line, causes no memory traffic, and marks the line dirty.
- R8: A dirty victim is first written to memory with mem_we high, at the block address formed from its stored tag and the set index, carrying its whole block; the refill read follows its acknowledge.
- R9: A clean victim is replaced without a memory write.
- R10: A store miss first refills the block (write-allocate) and then merges the store data into it.
- R11: cpu_be bit i enables byte i, bits [8i+7:8i], of the addressed 32-bit word; disabled bytes and all other words of the line keep their values.
- R12: A memory request holds mem_req, mem_we and mem_addr steady until mem_ack is seen high at a clock edge; the acknowledge latency may be any number of cycles.
- R13: mem_req is high only while cpu_stall is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Byte enables for a store, bit i selects byte i |
| cpu_rdata | output | 32 | Load data, valid in the cycle the access completes |
| cpu_stall | output | 1 | High while the access waits on memory |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a block write-back, 0 for a block read |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | BLOCK_BYTES*8 | Block being written back |
| mem_rdata | input | BLOCK_BYTES*8 | Block returned by memory, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |

## Verification
Hit data and the stall flag come from combinational lookup, so they are due in the same cycle the request is driven; the bench drives on the falling edge and samples 1 ns later, before the rising edge that commits the store or age update. On a miss the memory request appears one rising edge after the stall, the refill read follows one edge after a write-back acknowledge, and the completing cycle with stall low comes one edge after the refill acknowledge, so the bench polls stall on every falling edge and reads the data only in the first low cycle. The bench-side memory acknowledges after a latency that rotates among 0, 1 and 2 extra cycles and counts reads and write-backs, which is how victim choice and write-back are seen at the ports.

// File: rtl/cache_pkg.sv
// Shared definitions for the write-back cache controller.
// Assumes a 32-bit byte address and a 32-bit processor word.
package cache_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    // Controller sequence for one access.
    typedef enum logic [1:0] {
        ST_LOOKUP    = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_REFILL    = 2'd2,
        ST_RESPOND   = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/cache_lru.sv
// Per-set recency tracker. Each way of each set holds an age from 0
// (newest) to WAYS-1 (oldest); ages inside a set are always distinct.
// A touch makes the way newest and ages every younger way by one.
// Assumes WAYS >= 2 and SETS >= 2.
module cache_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] query_set,
    output logic [WAY_W-1:0] lru_way
);
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    // Seed distinct ages on reset, reorder on each touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    // Report the way holding the oldest age in the queried set.
    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[query_set][w] == WAY_W'(WAYS - 1))
                lru_way = WAY_W'(w);
    end
endmodule

// File: rtl/cache_victim.sv
// Victim chooser for one set: the lowest-numbered invalid way wins,
// otherwise the way named by the recency tracker is taken.
module cache_victim #(
    parameter int WAYS = 2,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] lru_i,
    output logic [WAY_W-1:0] victim_o
);
    // Scan downward so the lowest invalid way is the last one written.
    always_comb begin
        victim_o = lru_i;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid_i[w])
                victim_o = WAY_W'(w);
    end
endmodule

// File: rtl/cache_wb_ctrl.sv
// Set-associative write-back, write-allocate data cache controller.
// Hits complete combinationally in the cycle presented; misses stall the
// processor through write-back, refill and a respond cycle. Assumes the
// processor holds its request steady while cpu_stall is high, and that
// SETS, WAYS and BLOCK_BYTES are powers of two with SETS, WAYS >= 2 and
// BLOCK_BYTES >= 8.
module cache_wb_ctrl
    import cache_pkg::*;
#(
    parameter int SETS        = 4,
    parameter int WAYS        = 2,
    parameter int BLOCK_BYTES = 16,
    localparam int OFF_W   = $clog2(BLOCK_BYTES),
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int WSEL_W  = OFF_W - 2,
    localparam int BLOCK_W = BLOCK_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [31:0]        cpu_addr,
    input  logic [31:0]        cpu_wdata,
    input  logic [3:0]         cpu_be,
    output logic [31:0]        cpu_rdata,
    output logic               cpu_stall,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [BLOCK_W-1:0] mem_wdata,
    input  logic [BLOCK_W-1:0] mem_rdata,
    input  logic               mem_ack
);
    logic [WAYS-1:0]    valid_q [SETS];
    logic [WAYS-1:0]    dirty_q [SETS];
    logic [TAG_W-1:0]   tag_q   [SETS][WAYS];
    logic [BLOCK_W-1:0] data_q  [SETS][WAYS];

    ctl_state_t       state_q;
    logic [WAY_W-1:0] vict_q;

    logic [TAG_W-1:0]   req_tag;
    logic [IDX_W-1:0]   req_set;
    logic [WSEL_W-1:0]  req_word;
    logic [WAYS-1:0]    hit_vec;
    logic               hit;
    logic [WAY_W-1:0]   hit_way;
    logic [WAY_W-1:0]   lru_way;
    logic [WAY_W-1:0]   victim;
    logic [BLOCK_W-1:0] hit_line;
    logic [BLOCK_W-1:0] store_line;
    logic               access_done;
    logic               fill_done;
    logic               unused_addr_lsb;

    assign req_tag         = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_set         = cpu_addr[OFF_W +: IDX_W];
    assign req_word        = cpu_addr[2 +: WSEL_W];
    assign unused_addr_lsb = ^cpu_addr[1:0];

    // Per-way tag compare against the indexed set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[req_set][w] && (tag_q[req_set][w] == req_tag);
    end
    assign hit = |hit_vec;

    // Encode the matching way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w])
                hit_way = WAY_W'(w);
    end

    assign hit_line  = data_q[req_set][hit_way];
    assign cpu_rdata = hit_line[int'(req_word) * 32 +: 32];

    // Merge enabled store bytes into the hit line.
    always_comb begin
        store_line = hit_line;
        for (int b = 0; b < 4; b++)
            if (cpu_be[b])
                store_line[int'(req_word) * 32 + b * 8 +: 8] = cpu_wdata[b * 8 +: 8];
    end

    cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (access_done),
        .touch_set (req_set),
        .touch_way (hit_way),
        .query_set (req_set),
        .lru_way   (lru_way)
    );

    cache_victim #(.WAYS(WAYS)) u_victim (
        .valid_i  (valid_q[req_set]),
        .lru_i    (lru_way),
        .victim_o (victim)
    );

    assign access_done = cpu_req && hit && (state_q == ST_LOOKUP || state_q == ST_RESPOND);
    assign fill_done   = (state_q == ST_REFILL) && mem_ack;

    // Stall while a miss is outstanding; the respond cycle completes it.
    always_comb begin
        unique case (state_q)
            ST_LOOKUP:  cpu_stall = cpu_req && !hit;
            ST_RESPOND: cpu_stall = 1'b0;
            default:    cpu_stall = 1'b1;
        endcase
    end

    assign mem_req   = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
    assign mem_we    = (state_q == ST_WRITEBACK);
    assign mem_addr  = (state_q == ST_WRITEBACK)
                     ? {tag_q[req_set][vict_q], req_set, {OFF_W{1'b0}}}
                     : {req_tag, req_set, {OFF_W{1'b0}}};
    assign mem_wdata = data_q[req_set][vict_q];

    // Sequence a miss: pick victim, write back if dirty, refill, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
            vict_q  <= '0;
        end else begin
            unique case (state_q)
                ST_LOOKUP: if (cpu_req && !hit) begin
                    vict_q  <= victim;
                    state_q <= (valid_q[req_set][victim] && dirty_q[req_set][victim])
                             ? ST_WRITEBACK : ST_REFILL;
                end
                ST_WRITEBACK: if (mem_ack) state_q <= ST_REFILL;
                ST_REFILL:    if (mem_ack) state_q <= ST_RESPOND;
                default:      state_q <= ST_LOOKUP;
            endcase
        end
    end

    // Line flags: cleared by reset, set by refill and store hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (fill_done) begin
            valid_q[req_set][vict_q] <= 1'b1;
            dirty_q[req_set][vict_q] <= 1'b0;
        end else if (access_done && cpu_we) begin
            dirty_q[req_set][hit_way] <= 1'b1;
        end
    end

    // Tag and data arrays: loaded on refill, merged on store completion.
    always_ff @(posedge clk) begin
        if (fill_done) begin
            tag_q[req_set][vict_q]  <= req_tag;
            data_q[req_set][vict_q] <= mem_rdata;
        end else if (access_done && cpu_we) begin
            data_q[req_set][hit_way] <= store_line;
        end
    end
endmodule

// Protocol checker for cache_wb_ctrl, attached by bind below.
// Observes only the ports of the controller.
module cache_wb_ctrl_chk #(
    parameter int BLOCK_BYTES = 16,
    localparam int OFF_W = $clog2(BLOCK_BYTES)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_stall,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr
);
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R8
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R4
    blk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R4
    fill_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> !cpu_stall);

    // R13
    traffic_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall);
endmodule

bind cache_wb_ctrl cache_wb_ctrl_chk #(.BLOCK_BYTES(BLOCK_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/cache_wb_ctrl_tb.sv
`timescale 1ns/100ps
module cache_wb_ctrl_tb;
    localparam int BW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]   cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]    cpu_be = '0;
    logic [31:0]   cpu_rdata;
    logic          cpu_stall, mem_req, mem_we;
    logic [31:0]   mem_addr;
    logic [BW-1:0] mem_wdata;
    logic [BW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    int checks = 0, errors = 0, rd_cnt = 0, wb_cnt = 0, cycles = 0;
    logic [31:0]   last_wb_addr = '0;
    logic [BW-1:0] mem_blk [64];
    logic [31:0]   ref_mem [256];
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    cache_wb_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] seed_word(int i);
        return {8'hA5, 8'(i), 16'(i * 7 + 3)};
    endfunction

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic        miss;
        logic        wb;
        logic [31:0] wb_addr;
    } vec_t;

    // Set 0 lines: 0x000 0x040 0x080 0x0C0 0x100 0x180 0x1C0.
    localparam vec_t VECS [17] = '{
        '{1'b0, 32'h000, 32'h0,        4'h0, 1'b1, 1'b0, 32'h0},   // cold miss
        '{1'b0, 32'h004, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0},   // hit
        '{1'b0, 32'h040, 32'h0,        4'h0, 1'b1, 1'b0, 32'h0},   // fills invalid way
        '{1'b0, 32'h008, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0},   // first line kept
        '{1'b1, 32'h044, 32'h11223344, 4'hF, 1'b0, 1'b0, 32'h0},   // store hit
        '{1'b0, 32'h080, 32'h0,        4'h0, 1'b1, 1'b0, 32'h0},   // evict 0x000 clean
        '{1'b0, 32'h044, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0},   // cached store data
        '{1'b0, 32'h000, 32'h0,        4'h0, 1'b1, 1'b0, 32'h0},   // evict 0x080
        '{1'b0, 32'h0C0, 32'h0,        4'h0, 1'b1, 1'b1, 32'h040}, // dirty write-back
        '{1'b0, 32'h044, 32'h0,        4'h0, 1'b1, 1'b0, 32'h0},   // data from memory
        '{1'b1, 32'h108, 32'hDEADBEEF, 4'h5, 1'b1, 1'b0, 32'h0},   // store miss
        '{1'b0, 32'h108, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0},   // merged bytes
        '{1'b0, 32'h10C, 32'h0,        4'h0, 1'b0, 1'b0, 32'h0},   // neighbour word
        '{1'b0, 32'h014, 32'h0,        4'h0, 1'b1, 1'b0, 32'h0},   // other set
        '{1'b0, 32'h180, 32'h0,        4'h0, 1'b1, 1'b0, 32'h0},   // evict 0x040
        '{1'b0, 32'h1C0, 32'h0,        4'h0, 1'b1, 1'b1, 32'h100}, // evict dirty 0x100
        '{1'b0, 32'h108, 32'h0,        4'h0, 1'b1, 1'b0, 32'h0}    // reload merged
    };

    function automatic string vec_tag(int i);
        case (i)
            0:  return "R2/R4";
            1:  return "R3";
            2:  return "R5";
            3:  return "R5";
            4:  return "R7";
            5:  return "R6/R9";
            6:  return "R7";
            7:  return "R6";
            8:  return "R8";
            9:  return "R8";
            10: return "R10";
            11: return "R11";
            12: return "R11";
            13: return "R1";
            14: return "R6";
            15: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory model with rotating acknowledge latency (R12).
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && rst_n) begin
                repeat (lat) @(negedge clk);
                if (mem_we) begin
                    mem_blk[mem_addr[9:4]] = mem_wdata;
                    wb_cnt++;
                    last_wb_addr = mem_addr;
                end else begin
                    mem_rdata = mem_blk[mem_addr[9:4]];
                    rd_cnt++;
                end
                mem_ack = 1'b1;
                lat = (lat + 1) % 3;
            end
        end
    end

    // One processor access, called at a falling edge.
    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input logic exp_miss, input logic exp_wb,
                          input logic [31:0] exp_wba, input string tag);
        int rd0 = rd_cnt, wb0 = wb_cnt, n = 0;
        logic first_stall;
        logic [31:0] exp_data = ref_mem[a[9:2]];
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        #1;
        first_stall = cpu_stall;
        while (cpu_stall && n < 1000) begin
            @(negedge clk); #1; n++;
        end
        check(first_stall == exp_miss, tag, "stall on present", 32'(first_stall), 32'(exp_miss));
        check(!mem_req, "R13", "mem_req at completion", 32'(mem_req), 32'h0);
        if (!we)
            check(cpu_rdata == exp_data, tag, "load data", cpu_rdata, exp_data);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        check((rd_cnt - rd0) == int'(exp_miss), exp_miss ? "R4" : "R3", "block reads",
              32'(rd_cnt - rd0), 32'(exp_miss));
        check((wb_cnt - wb0) == int'(exp_wb), exp_wb ? "R8" : "R9", "write-backs",
              32'(wb_cnt - wb0), 32'(exp_wb));
        if (exp_wb)
            check(last_wb_addr == exp_wba, "R8", "write-back address", last_wb_addr, exp_wba);
        if (we)
            for (int b = 0; b < 4; b++)
                if (be[b]) ref_mem[a[9:2]][b*8 +: 8] = wd[b*8 +: 8];
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk); cycles++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = seed_word(i);
        for (int k = 0; k < 64; k++)
            for (int j = 0; j < 4; j++)
                mem_blk[k][j*32 +: 32] = seed_word(k * 4 + j);

        repeat (3) @(negedge clk);
        // R2: outputs idle during reset
        check(!cpu_stall && !mem_req, "R2", "idle in reset", {cpu_stall, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_stall && !mem_req, "R2", "idle after reset", {cpu_stall, mem_req}, 32'h0);

        foreach (VECS[i])
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be,
                   VECS[i].miss, VECS[i].wb, VECS[i].wb_addr, vec_tag(i));

        // R2: reset empties the cache (no dirty lines remain at this point)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 32'h044, '0, '0, 1'b1, 1'b0, '0, "R2");
        // R1: index bits [5:4] separate sets, tag separates same-set blocks
        access(1'b0, 32'h054, '0, '0, 1'b1, 1'b0, '0, "R1");
        access(1'b0, 32'h048, '0, '0, 1'b0, 1'b0, '0, "R1");
        access(1'b0, 32'h244, '0, '0, 1'b1, 1'b0, '0, "R5");
        access(1'b0, 32'h040, '0, '0, 1'b0, 1'b0, '0, "R5");
        // R11: only byte 3 of word 0x040 written; R7: no memory traffic
        access(1'b1, 32'h040, 32'h77665544, 4'h8, 1'b0, 1'b0, '0, "R7");
        access(1'b0, 32'h040, '0, '0, 1'b0, 1'b0, '0, "R11");
        access(1'b0, 32'h04C, '0, '0, 1'b0, 1'b0, '0, "R11");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule